// File: doc/BRIEF.md
# Audio Port Register Block

This block is the software-visible control and status file of a serial audio port. It sits on a simple single-cycle register bus with 32-bit word-aligned accesses. It holds the enable levels of the receiver, the transmitter and the clock generator, and it keeps a set of sticky event flags that the serial datapath raises through one-cycle pulses. From those flags and an interrupt mask it builds a level interrupt. The serial shifter, the DMA engine and the clock dividers sit outside and connect to the exported levels, the mode word and the holding-register strobes.

The control word is write-only and acts only on the bits written as 1, so separate enable and disable strobes let software change one function without a read-modify-write. Status flags can be cleared or forced by writing ones to two companion addresses. Receive overrun and transmit underrun are also recorded per channel, using the channel index that comes with the datapath pulse.

Top module: `apc_regs`

## Requirements
- R1: A control write (byte offset 0x00) with bit 0, 2 or 4 at 1 turns on the receiver, clock generator or transmitter respectively, and a write with bit 1, 3 or 5 at 1 turns it off. Bits written as 0 leave the matching level unchanged. The receiver and transmitter levels also read back at status bits 0 and 4.
- R2: If one control write sets both the on bit and the off bit of the same function, that function ends up off.
- R3: A control write with bit 7 at 1 clears the mode word, the interrupt mask, every status flag, the transmit holding value and all three enables. This happens even if the same write also carries enable bits. The version word is not affected.
- R4: Datapath pulses set sticky status flags: receive ready sets bit 1, transmit ready sets bit 5, receive overrun sets bit 2 and bit 8+channel, and transmit underrun sets bit 6 and bit 20+channel. The status word is read at 0x08. Each flag stays set until it is cleared.
- R5: Writing ones to 0x0C clears the matching sticky flags, and writing ones to 0x10 forces them high. A datapath pulse in the same cycle as a clear write leaves its flag set.
- R6: Writing ones to 0x14 sets interrupt mask bits, and writing ones to 0x18 clears them. Only bits 1, 2, 5 and 6 can be held, and the mask reads back at 0x1C.
- R7: The interrupt output is high exactly when some status bit among 1, 2, 5 and 6 is set and its mask bit is set.
- R8: A read of 0x20 returns the receive holding input and raises the pop strobe in the same cycle. From the next cycle on, status bit 1 is clear unless a new receive-ready pulse arrived in that same cycle.
- R9: A write to 0x24 puts the written word on the transmit holding output and raises the load strobe for exactly the following cycle. It also clears status bit 5.
- R10: The mode word at 0x04 stores all 32 written bits, reads them back, and drives the mode output.
- R11: Reads of 0x00, 0x0C, 0x10, 0x14, 0x18, 0x24 and of unmapped offsets return zero, and 0x28 returns the VERSION parameter. Accesses whose two low address bits are not zero are ignored and read zero.
- R12: Status bits 0 and 4 follow only the enables; writes to 0x0C and 0x10 do not affect them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the access |
| rx_hold_i | input | 32 | Received sample presented by the datapath |
| rx_pop_o | output | 1 | Receive holding word taken this cycle |
| tx_hold_o | output | 32 | Last transmit holding word written |
| tx_load_o | output | 1 | New transmit word, one cycle after the write |
| mode_o | output | 32 | Mode word for the datapath |
| ev_rx_rdy | input | 1 | Receive ready pulse |
| ev_rx_ovr | input | 1 | Receive overrun pulse |
| ev_tx_rdy | input | 1 | Transmit ready pulse |
| ev_tx_udr | input | 1 | Transmit underrun pulse |
| ev_chan | input | clog2(NCH) | Channel of an overrun or underrun pulse |
| rx_on_o | output | 1 | Receiver enable level |
| tx_on_o | output | 1 | Transmitter enable level |
| clk_on_o | output | 1 | Clock generator enable level |
| irq_o | output | 1 | Level interrupt |

## Verification
A read returns data within the cycle of the access, so the bench samples bus_rdata shortly after driving the address and before the next edge. Every write and every datapath pulse updates state at the edge that closes its cycle, and the interrupt, the enables and the status read reflect it from that edge on. The bench therefore samples these one falling edge after the stimulus. The load strobe is registered: it is checked high on the falling edge right after the write and low one cycle later. The pop strobe is combinational and is checked while the read is driven, and the clearing of receive ready is checked by a read on the following cycle.

// File: rtl/apc_pkg.sv
package apc_pkg;
    // word indices (byte offset / 4)
    localparam int unsigned W_CTRL = 0;
    localparam int unsigned W_MODE = 1;
    localparam int unsigned W_STAT = 2;
    localparam int unsigned W_SCLR = 3;
    localparam int unsigned W_SSET = 4;
    localparam int unsigned W_IEN  = 5;
    localparam int unsigned W_IDIS = 6;
    localparam int unsigned W_IMSK = 7;
    localparam int unsigned W_RHLD = 8;
    localparam int unsigned W_THLD = 9;
    localparam int unsigned W_VER  = 10;

    // control word bits
    localparam int unsigned C_RX_EN  = 0;
    localparam int unsigned C_RX_DIS = 1;
    localparam int unsigned C_CK_EN  = 2;
    localparam int unsigned C_CK_DIS = 3;
    localparam int unsigned C_TX_EN  = 4;
    localparam int unsigned C_TX_DIS = 5;
    localparam int unsigned C_RST    = 7;

    // status word bits
    localparam int unsigned B_RX_ON  = 0;
    localparam int unsigned B_RX_RDY = 1;
    localparam int unsigned B_RX_OVR = 2;
    localparam int unsigned B_TX_ON  = 4;
    localparam int unsigned B_TX_RDY = 5;
    localparam int unsigned B_TX_UDR = 6;
    localparam int unsigned B_OVR_CH = 8;
    localparam int unsigned B_UDR_CH = 20;

    localparam logic [31:0] IRQ_SRC = 32'h0000_0066;

    typedef struct packed {
        logic rx;
        logic tx;
        logic ck;
    } en_t;

    typedef struct packed {
        logic [31:0] sticky;
        logic [31:0] mask;
    } stat_t;

    typedef struct packed {
        logic [31:0] mode;
        logic [31:0] hold;
        logic        load;
    } top_t;
endpackage

// File: rtl/apc_ctrl.sv
module apc_ctrl
    import apc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       sw_rst,
    input  logic [5:0] cmd,
    output logic       rx_on,
    output logic       tx_on,
    output logic       ck_on
);
    en_t en_d, en_q;

    function automatic logic pick(input logic cur, input logic on, input logic off);
        return off ? 1'b0 : (on ? 1'b1 : cur);
    endfunction

    always_comb begin
        en_d = en_q;
        if (sw_rst) begin
            en_d = '0;
        end else if (wr) begin
            en_d.rx = pick(en_q.rx, cmd[C_RX_EN], cmd[C_RX_DIS]);
            en_d.ck = pick(en_q.ck, cmd[C_CK_EN], cmd[C_CK_DIS]);
            en_d.tx = pick(en_q.tx, cmd[C_TX_EN], cmd[C_TX_DIS]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign rx_on = en_q.rx;
    assign tx_on = en_q.tx;
    assign ck_on = en_q.ck;
endmodule

// File: rtl/apc_status.sv
module apc_status
    import apc_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sw_rst,
    input  logic                    wr_clr,
    input  logic                    wr_set,
    input  logic                    wr_ien,
    input  logic                    wr_idis,
    input  logic                    rd_hold,
    input  logic                    wr_hold,
    input  logic [31:0]             wdata,
    input  logic                    ev_rx_rdy,
    input  logic                    ev_rx_ovr,
    input  logic                    ev_tx_rdy,
    input  logic                    ev_tx_udr,
    input  logic [$clog2(NCH)-1:0]  ev_chan,
    output logic [31:0]             sticky_q,
    output logic [31:0]             mask_q,
    output logic                    irq
);
    localparam int CH_W = $clog2(NCH);
    localparam logic [31:0] CH_ONES = 32'((64'd1 << NCH) - 64'd1);
    localparam logic [31:0] KEEP = IRQ_SRC | (CH_ONES << B_OVR_CH) | (CH_ONES << B_UDR_CH);

    stat_t st_d, st_q;
    logic [NCH-1:0] ovr_hit, udr_hit;
    logic [31:0] ev_vec, pop_vec, clr_vec, set_vec;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign ovr_hit[c] = ev_rx_ovr && (ev_chan == CH_W'(c));
        assign udr_hit[c] = ev_tx_udr && (ev_chan == CH_W'(c));
    end

    always_comb begin
        ev_vec = '0;
        ev_vec[B_RX_RDY] = ev_rx_rdy;
        ev_vec[B_RX_OVR] = ev_rx_ovr;
        ev_vec[B_TX_RDY] = ev_tx_rdy;
        ev_vec[B_TX_UDR] = ev_tx_udr;
        ev_vec[B_OVR_CH +: NCH] = ovr_hit;
        ev_vec[B_UDR_CH +: NCH] = udr_hit;

        pop_vec = '0;
        pop_vec[B_RX_RDY] = rd_hold;
        pop_vec[B_TX_RDY] = wr_hold;

        clr_vec = wr_clr ? wdata : '0;
        set_vec = wr_set ? wdata : '0;

        st_d.sticky = ((st_q.sticky & ~clr_vec & ~pop_vec) | set_vec | ev_vec) & KEEP;
        st_d.mask   = ((st_q.mask | (wr_ien ? wdata : '0)) & ~(wr_idis ? wdata : '0)) & IRQ_SRC;
        if (sw_rst) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sticky_q = st_q.sticky;
    assign mask_q   = st_q.mask;
    assign irq      = |(st_q.sticky & st_q.mask);
endmodule

// File: rtl/apc_rdmux.sv
module apc_rdmux
    import apc_pkg::*;
#(
    parameter int          WORD_W  = 4,
    parameter logic [31:0] VERSION = 32'h0000_0210
) (
    input  logic              rd,
    input  logic [WORD_W-1:0] word,
    input  logic [31:0]       mode,
    input  logic [31:0]       sticky,
    input  logic [31:0]       mask,
    input  logic              rx_on,
    input  logic              tx_on,
    input  logic [31:0]       rx_hold,
    output logic [31:0]       rdata
);
    logic [31:0] st_view;

    always_comb begin
        st_view = sticky;
        st_view[B_RX_ON] = rx_on;
        st_view[B_TX_ON] = tx_on;
        rdata = '0;
        if (rd) begin
            case (word)
                WORD_W'(W_MODE): rdata = mode;
                WORD_W'(W_STAT): rdata = st_view;
                WORD_W'(W_IMSK): rdata = mask;
                WORD_W'(W_RHLD): rdata = rx_hold;
                WORD_W'(W_VER):  rdata = VERSION;
                default:         rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/apc_regs.sv
module apc_regs
    import apc_pkg::*;
#(
    parameter int          ADDR_W  = 6,
    parameter int          NCH     = 8,
    parameter logic [31:0] VERSION = 32'h0000_0210
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [31:0]            rx_hold_i,
    output logic                   rx_pop_o,
    output logic [31:0]            tx_hold_o,
    output logic                   tx_load_o,
    output logic [31:0]            mode_o,
    input  logic                   ev_rx_rdy,
    input  logic                   ev_rx_ovr,
    input  logic                   ev_tx_rdy,
    input  logic                   ev_tx_udr,
    input  logic [$clog2(NCH)-1:0] ev_chan,
    output logic                   rx_on_o,
    output logic                   tx_on_o,
    output logic                   clk_on_o,
    output logic                   irq_o
);
    localparam int WORD_W = ADDR_W - 2;

    logic acc, wr, rd;
    logic [WORD_W-1:0] word;
    logic wr_ctrl, wr_mode, wr_sclr, wr_sset, wr_ien, wr_idis, wr_thld, rd_rhld, sw_rst;
    logic [31:0] stat_sticky, stat_mask;
    top_t top_d, top_q;

    assign acc  = bus_sel && (bus_addr[1:0] == 2'b00);
    assign wr   = acc && bus_wr;
    assign rd   = acc && !bus_wr;
    assign word = bus_addr[ADDR_W-1:2];

    assign wr_ctrl = wr && (word == WORD_W'(W_CTRL));
    assign wr_mode = wr && (word == WORD_W'(W_MODE));
    assign wr_sclr = wr && (word == WORD_W'(W_SCLR));
    assign wr_sset = wr && (word == WORD_W'(W_SSET));
    assign wr_ien  = wr && (word == WORD_W'(W_IEN));
    assign wr_idis = wr && (word == WORD_W'(W_IDIS));
    assign wr_thld = wr && (word == WORD_W'(W_THLD));
    assign rd_rhld = rd && (word == WORD_W'(W_RHLD));
    assign sw_rst  = wr_ctrl && bus_wdata[C_RST];

    always_comb begin
        top_d      = top_q;
        top_d.load = wr_thld;
        if (wr_mode) top_d.mode = bus_wdata;
        if (wr_thld) top_d.hold = bus_wdata;
        if (sw_rst)  top_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    apc_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_ctrl),
        .sw_rst (sw_rst),
        .cmd    (bus_wdata[5:0]),
        .rx_on  (rx_on_o),
        .tx_on  (tx_on_o),
        .ck_on  (clk_on_o)
    );

    apc_status #(.NCH(NCH)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst    (sw_rst),
        .wr_clr    (wr_sclr),
        .wr_set    (wr_sset),
        .wr_ien    (wr_ien),
        .wr_idis   (wr_idis),
        .rd_hold   (rd_rhld),
        .wr_hold   (wr_thld),
        .wdata     (bus_wdata),
        .ev_rx_rdy (ev_rx_rdy),
        .ev_rx_ovr (ev_rx_ovr),
        .ev_tx_rdy (ev_tx_rdy),
        .ev_tx_udr (ev_tx_udr),
        .ev_chan   (ev_chan),
        .sticky_q  (stat_sticky),
        .mask_q    (stat_mask),
        .irq       (irq_o)
    );

    apc_rdmux #(.WORD_W(WORD_W), .VERSION(VERSION)) u_rdmux (
        .rd      (rd),
        .word    (word),
        .mode    (top_q.mode),
        .sticky  (stat_sticky),
        .mask    (stat_mask),
        .rx_on   (rx_on_o),
        .tx_on   (tx_on_o),
        .rx_hold (rx_hold_i),
        .rdata   (bus_rdata)
    );

    assign rx_pop_o  = rd_rhld;
    assign tx_hold_o = top_q.hold;
    assign tx_load_o = top_q.load;
    assign mode_o    = top_q.mode;
endmodule

// File: rtl/apc_regs_chk.sv
module apc_regs_chk
    import apc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              w_rx_en,
    input logic              w_rx_dis,
    input logic              w_rst,
    input logic              ev_rx_rdy,
    input logic              ev_rx_ovr,
    input logic              ev_tx_rdy,
    input logic              ev_tx_udr,
    input logic              rx_pop_o,
    input logic              tx_load_o,
    input logic              rx_on_o,
    input logic              tx_on_o,
    input logic              clk_on_o,
    input logic              irq_o,
    input logic              rx_rdy_bit,
    input logic              ovr_bit
);
    logic ctrl_wr, thr_wr, ev_any;
    assign ctrl_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(W_CTRL * 4));
    assign thr_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(W_THLD * 4));
    assign ev_any  = ev_rx_rdy || ev_rx_ovr || ev_tx_rdy || ev_tx_udr;

    assert_rx_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && w_rx_en && !w_rx_dis && !w_rst) |=> rx_on_o);

    assert_disable_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && w_rx_dis) |=> !rx_on_o);

    assert_swrst_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && w_rst) |=> (!rx_on_o && !tx_on_o && !clk_on_o && !irq_o && !rx_rdy_bit));

    assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_ovr && !(ctrl_wr && w_rst)) |=> ovr_bit);

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(ev_any || (bus_sel && bus_wr)));

    assert_pop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop_o && !ev_rx_rdy) |=> !rx_rdy_bit);

    assert_load_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_o |-> $past(thr_wr));
endmodule

bind apc_regs apc_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .w_rx_en    (bus_wdata[0]),
    .w_rx_dis   (bus_wdata[1]),
    .w_rst      (bus_wdata[7]),
    .ev_rx_rdy  (ev_rx_rdy),
    .ev_rx_ovr  (ev_rx_ovr),
    .ev_tx_rdy  (ev_tx_rdy),
    .ev_tx_udr  (ev_tx_udr),
    .rx_pop_o   (rx_pop_o),
    .tx_load_o  (tx_load_o),
    .rx_on_o    (rx_on_o),
    .tx_on_o    (tx_on_o),
    .clk_on_o   (clk_on_o),
    .irq_o      (irq_o),
    .rx_rdy_bit (stat_sticky[1]),
    .ovr_bit    (stat_sticky[2])
);

// File: tb/tb_apc_regs.sv
`timescale 1ns/1ps
module tb_apc_regs;
    localparam logic [31:0] VER = 32'h0000_0210;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, rx_hold_i = '0, tx_hold_o, mode_o;
    logic rx_pop_o, tx_load_o, rx_on_o, tx_on_o, clk_on_o, irq_o;
    logic ev_rx_rdy = 1'b0, ev_rx_ovr = 1'b0, ev_tx_rdy = 1'b0, ev_tx_udr = 1'b0;
    logic [2:0] ev_chan = '0;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [31:0] rv;
    logic pop_seen;

    always #5 clk = ~clk;

    apc_regs #(.ADDR_W(6), .NCH(8), .VERSION(VER)) dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        rv = bus_rdata;
        pop_seen = rx_pop_o;
        @(negedge clk);
        bus_sel = 0;
    endtask

    // kind: 0 rx ready, 1 overrun, 2 tx ready, 3 underrun
    task automatic pulse(input int kind, input int ch);
        @(negedge clk);
        ev_chan = 3'(ch);
        ev_rx_rdy = (kind == 0); ev_rx_ovr = (kind == 1);
        ev_tx_rdy = (kind == 2); ev_tx_udr = (kind == 3);
        @(negedge clk);
        ev_rx_rdy = 0; ev_rx_ovr = 0; ev_tx_rdy = 0; ev_tx_udr = 0;
    endtask

    function automatic logic [31:0] spread(input logic [3:0] m);
        return {25'b0, m[3], m[2], 2'b0, m[1], m[0], 1'b0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // reset state and version (R11)
        rd(6'h28); check("R11 version", rv, VER);
        rd(6'h08); check("R4 status after reset", rv, 0);
        rd(6'h04); check("R10 mode after reset", rv, 0);
        rd(6'h1C); check("R6 mask after reset", rv, 0);
        check("R7 irq after reset", {28'b0, irq_o, rx_on_o, tx_on_o, clk_on_o}, 0);

        // R10 mode word
        foreach (exp[i]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [31:0] pat;
            pat = (k == 0) ? 32'hA5A5_5A5A : (k == 1) ? 32'hFFFF_FFFF : (k == 2) ? 32'h1 : 32'h8000_0000;
            wr(6'h04, pat);
            rd(6'h04); check("R10 mode readback", rv, pat);
            check("R10 mode output", mode_o, pat);
        end

        // R11 write-only and unmapped reads, misaligned access
        for (int k = 0; k < 8; k++) begin
            logic [5:0] a;
            a = (k == 0) ? 6'h00 : (k == 1) ? 6'h0C : (k == 2) ? 6'h10 : (k == 3) ? 6'h14 :
                (k == 4) ? 6'h18 : (k == 5) ? 6'h24 : (k == 6) ? 6'h2C : 6'h3C;
            rd(a); check("R11 zero read", rv, 0);
        end
        wr(6'h05, 32'h1234_0000);
        check("R11 misaligned write ignored", mode_o, 32'h8000_0000);
        rd(6'h29); check("R11 misaligned read zero", rv, 0);

        // R1 R2 sweep over prior state and all strobe combinations
        for (int s = 0; s < 8; s++) begin
            for (int p = 0; p < 64; p++) begin
                logic erx, etx, eck;
                wr(6'h00, 32'h2A);
                wr(6'h00, {27'b0, s[1], 1'b0, s[2], 1'b0, s[0]});
                wr(6'h00, 32'(p));
                erx = p[1] ? 1'b0 : (p[0] ? 1'b1 : s[0]);
                eck = p[3] ? 1'b0 : (p[2] ? 1'b1 : s[2]);
                etx = p[5] ? 1'b0 : (p[4] ? 1'b1 : s[1]);
                rd(6'h08);
                check("R1 R2 enable sweep status", rv, {27'b0, etx, 3'b0, erx});
                check("R1 R2 enable sweep ports", {29'b0, rx_on_o, tx_on_o, clk_on_o}, {29'b0, erx, etx, eck});
            end
        end
        wr(6'h00, 32'h2A);

        // R4 per-channel flags
        wr(6'h00, 32'h80);
        exp = 0;
        for (int ch = 0; ch < 8; ch++) begin
            pulse(1, ch);
            exp |= (32'h4 | (32'h1 << (8 + ch)));
            rd(6'h08); check("R4 overrun channel", rv, exp);
        end
        for (int ch = 0; ch < 8; ch++) begin
            pulse(3, ch);
            exp |= (32'h40 | (32'h1 << (20 + ch)));
            rd(6'h08); check("R4 underrun channel", rv, exp);
        end
        pulse(0, 0); pulse(2, 0);
        exp |= 32'h22;
        rd(6'h08); check("R4 ready flags", rv, exp);

        // R5 clear and set
        wr(6'h0C, 32'h00AA_AA04);
        exp &= ~32'h00AA_AA04;
        rd(6'h08); check("R5 partial clear", rv, exp);
        wr(6'h0C, 32'hFFFF_FFFF);
        rd(6'h08); check("R5 full clear", rv, 0);
        wr(6'h10, 32'hFFFF_FFFF);
        rd(6'h08); check("R5 force all", rv, 32'h0FF0_FF66);
        wr(6'h0C, 32'hFFFF_FFFF);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 6'h0C; bus_wdata = 32'h2; ev_rx_rdy = 1;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; ev_rx_rdy = 0;
        rd(6'h08); check("R5 event beats clear", rv, 32'h2);

        // R12 enable bits immune to clear/set
        wr(6'h00, 32'h11);
        wr(6'h0C, 32'hFFFF_FFFF);
        rd(6'h08); check("R12 clear keeps enables", rv, 32'h11);
        wr(6'h00, 32'h22);
        wr(6'h10, 32'h11);
        rd(6'h08); check("R12 set ignores enable bits", rv, 0);

        // R6 R7 mask and interrupt sweep
        for (int m = 0; m < 16; m++) begin
            for (int s = 0; s < 16; s++) begin
                wr(6'h00, 32'h80);
                wr(6'h14, spread(4'(m)) | 32'hFFFF_FF00);
                wr(6'h10, spread(4'(s)));
                check("R7 irq level", {31'b0, irq_o}, {31'b0, |(4'(m) & 4'(s))});
                rd(6'h1C); check("R6 mask readback", rv, spread(4'(m)));
            end
        end
        wr(6'h00, 32'h80);
        wr(6'h14, 32'h66);
        wr(6'h10, 32'h4);
        check("R7 irq set", {31'b0, irq_o}, 1);
        wr(6'h18, 32'h4);
        check("R6 disable drops irq", {31'b0, irq_o}, 0);
        rd(6'h1C); check("R6 mask after disable", rv, 32'h62);

        // R8 receive holding read
        wr(6'h00, 32'h80);
        rx_hold_i = 32'hCAFE_0123;
        pulse(0, 0);
        rd(6'h08); check("R8 ready before read", rv, 32'h2);
        check("R8 no pop on status read", {31'b0, pop_seen}, 0);
        rd(6'h20); check("R8 holding data", rv, 32'hCAFE_0123);
        check("R8 pop strobe", {31'b0, pop_seen}, 1);
        rd(6'h08); check("R8 ready cleared", rv, 0);

        // R9 transmit holding write
        pulse(2, 0);
        wr(6'h24, 32'h1234_5678);
        check("R9 load strobe", {31'b0, tx_load_o}, 1);
        check("R9 hold value", tx_hold_o, 32'h1234_5678);
        @(negedge clk);
        check("R9 load one cycle", {31'b0, tx_load_o}, 0);
        rd(6'h08); check("R9 tx ready cleared", rv, 0);

        // R3 software reset
        wr(6'h04, 32'h0000_FFFF);
        wr(6'h14, 32'h66);
        wr(6'h10, 32'hFFFF_FFFF);
        wr(6'h00, 32'h15);
        check("R3 setup irq", {31'b0, irq_o}, 1);
        wr(6'h00, 32'h95);
        rd(6'h08); check("R3 status cleared", rv, 0);
        rd(6'h04); check("R3 mode cleared", rv, 0);
        rd(6'h1C); check("R3 mask cleared", rv, 0);
        check("R3 hold cleared", tx_hold_o, 0);
        check("R3 enables and irq", {28'b0, irq_o, rx_on_o, tx_on_o, clk_on_o}, 0);
        rd(6'h28); check("R3 version kept", rv, VER);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule